// File: doc/BRIEF.md
# Bank-Switched Memory Address Mapper

This block sits between a processor's 16-bit address bus and three byte-wide stores: a main RAM bank, an auxiliary RAM bank and a system ROM. For every read or write strobe it decides which store is touched, at which physical address, and whether a write is allowed. It does this from four banking flags held elsewhere: a RAM-read flag, a write-enable flag, a bank-2 flag and an alternate-stack flag.

Two address windows are remapped. The upper window, 0xD000 to 0xFFFF, can be served from ROM or RAM. Its first 4 KiB has a second RAM bank that is stored at a fixed offset above the 64 KiB mark of each RAM bank. The low window, 0x0000 to 0x01FF, holds the zero page and the stack. It follows its own main/aux choice. Every other address goes straight to main RAM. Each RAM bank is 68 KiB, so physical addresses are 17 bits wide. The stores register their read data. The block then returns the byte from the store that the read selected, one cycle after the strobe.

Top module: `bank_mapper`

## Requirements
- R1: For an access to 0x0000–0x01FF, the target is aux RAM (mem_sel 2) when the alternate-stack flag is 1 and main RAM (mem_sel 1) when it is 0, for reads and writes alike. The physical address equals the bus address.
- R2: A read in 0xD000–0xFFFF with the RAM-read flag at 0 targets ROM (mem_sel 3) at physical address (address − 0xD000).
- R3: A RAM access in 0xD000–0xDFFF with the bank-2 flag at 1 goes to physical address (address + 0x3000), which lies in 0x10000–0x10FFF. Data stored there is kept apart from the data at the same bus address with bank 2 at 0.
- R4: A RAM access in 0xE000–0xFFFF, or in 0xD000–0xDFFF with the bank-2 flag at 0, uses the bus address unchanged as the physical address.
- R5: A RAM access in 0xD000–0xFFFF targets aux RAM when the alternate-stack flag is 1 and main RAM when it is 0.
- R6: A write in 0xD000–0xFFFF with the write-enable flag at 0 raises no write strobe and selects no store (mem_sel 0). The stored byte is left unchanged.
- R7: A write never targets ROM. A write in 0xD000–0xFFFF with RAM-read at 0 and write-enable at 1 lands in RAM at the R3/R4 address. Reads there still come from ROM.
- R8: An access to 0x0200–0xCFFF targets main RAM at the unchanged address, whatever the flags.
- R9: rd_valid is 1 exactly in the cycle after a read strobe was issued. rd_data then carries the registered byte of the store that the read selected.
- R10: With neither strobe raised, mem_sel is 0 and mem_re and mem_we are 0.
- R11: When read and write strobes are both raised, the access is handled as a write only. mem_re stays 0 and the write rules apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | Bus address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| flag_ram_rd | input | 1 | Upper window reads come from RAM when 1, ROM when 0 |
| flag_wr_en | input | 1 | Upper window writes allowed when 1 |
| flag_bank2 | input | 1 | Use the second 4 KiB bank for 0xD000–0xDFFF |
| flag_alt_zp | input | 1 | Serve stack/zero page and upper-window RAM from aux |
| mem_sel | output | 2 | Store select: 0 none, 1 main, 2 aux, 3 ROM |
| mem_addr | output | 17 | Physical address in the selected store |
| mem_re | output | 1 | Read strobe to the selected store |
| mem_we | output | 1 | Write strobe to the selected store |
| mem_wdata | output | 8 | Write data to the store |
| main_rdata | input | 8 | Registered read data of main RAM |
| aux_rdata | input | 8 | Registered read data of aux RAM |
| rom_rdata | input | 8 | Registered read data of ROM |
| rd_data | output | 8 | Returned read byte |
| rd_valid | output | 1 | rd_data is valid |

## Verification
The assertions check several rules on every cycle: the low-window target choice, the ROM routing and offset for unprotected reads, the write block when write-enable is 0, the ban on writes to ROM, the pass-through of the middle range, the idle state, and the one-cycle timing of rd_valid. Some behaviour can only be shown by the directed scenarios. These are that a byte written with bank 2 on is kept apart from the byte at the same address with bank 2 off, that a blocked write leaves the old byte in place, that a write under ROM is read back once RAM-read is set, and that the returned byte comes from the store the read selected.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_MAIN = 2'd1,
    SEL_AUX  = 2'd2,
    SEL_ROM  = 2'd3
  } sel_e;

  typedef enum logic [1:0] {
    REG_OTHER  = 2'd0,
    REG_LOW    = 2'd1,
    REG_SWITCH = 2'd2
  } region_e;

  typedef struct packed {
    logic ram_rd;
    logic wr_en;
    logic bank2;
    logic alt_zp;
  } bank_flags_t;

endpackage

// File: rtl/bank_region_decode.sv
module bank_region_decode
  import bank_map_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] LOW_END  = 16'h0200,
  parameter logic [ADDR_W-1:0] SW_BASE  = 16'hD000,
  parameter logic [ADDR_W-1:0] FOLD_END = 16'hE000
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic              fold_win
);

  function automatic region_e classify(input logic [ADDR_W-1:0] a);
    if (a < LOW_END)       return REG_LOW;
    else if (a >= SW_BASE) return REG_SWITCH;
    else                   return REG_OTHER;
  endfunction

  always_comb begin
    region   = classify(addr);
    fold_win = (addr >= SW_BASE) && (addr < FOLD_END);
  end

endmodule

// File: rtl/bank_addr_xlate.sv
module bank_addr_xlate
  import bank_map_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PHYS_W = 17,
  parameter logic [ADDR_W-1:0] SW_BASE  = 16'hD000,
  parameter logic [PHYS_W-1:0] FOLD_OFS = 17'h03000
) (
  input  logic [ADDR_W-1:0] addr,
  input  region_e           region,
  input  logic              fold_win,
  input  bank_flags_t       flags,
  input  logic              do_rd,
  input  logic              do_wr,
  output sel_e              sel,
  output logic [PHYS_W-1:0] phys,
  output logic              wr_blocked,
  output logic              rom_path
);

  function automatic logic [PHYS_W-1:0] widen(input logic [ADDR_W-1:0] a);
    return PHYS_W'(a);
  endfunction

  function automatic logic [PHYS_W-1:0] rom_offset(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] d;
    d = a - SW_BASE;
    return widen(d);
  endfunction

  function automatic logic [PHYS_W-1:0] fold(input logic [ADDR_W-1:0] a,
                                             input logic b2, input logic win);
    return (b2 && win) ? (widen(a) + FOLD_OFS) : widen(a);
  endfunction

  function automatic sel_e ram_of(input logic alt);
    return alt ? SEL_AUX : SEL_MAIN;
  endfunction

  always_comb begin
    sel        = SEL_NONE;
    phys       = widen(addr);
    wr_blocked = 1'b0;
    rom_path   = 1'b0;
    case (region)
      REG_LOW: sel = ram_of(flags.alt_zp);
      REG_SWITCH: begin
        if (do_wr) begin
          if (flags.wr_en) begin
            sel  = ram_of(flags.alt_zp);
            phys = fold(addr, flags.bank2, fold_win);
          end else begin
            wr_blocked = 1'b1;
          end
        end else if (!flags.ram_rd) begin
          sel      = SEL_ROM;
          phys     = rom_offset(addr);
          rom_path = 1'b1;
        end else begin
          sel  = ram_of(flags.alt_zp);
          phys = fold(addr, flags.bank2, fold_win);
        end
      end
      default: sel = SEL_MAIN;
    endcase
    if (!(do_rd || do_wr)) begin
      sel        = SEL_NONE;
      wr_blocked = 1'b0;
      rom_path   = 1'b0;
    end
  end

endmodule

// File: rtl/bank_rdata_mux.sv
module bank_rdata_mux
  import bank_map_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int N_SRC  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  sel_e                    sel,
  input  logic                    re,
  input  logic [N_SRC*DATA_W-1:0] src_flat,
  output logic [DATA_W-1:0]       rd_data,
  output logic                    rd_valid
);

  sel_e sel_q;
  logic [N_SRC-1:0][DATA_W-1:0] masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= SEL_NONE;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= re;
      if (re) sel_q <= sel;
    end
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign masked[g] = (sel_q == sel_e'(g + 1)) ?
                       src_flat[g*DATA_W +: DATA_W] : '0;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_SRC; i++) rd_data = rd_data | masked[i];
  end

endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bank_map_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PHYS_W = 17,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] LOW_END  = 16'h0200,
  parameter logic [ADDR_W-1:0] SW_BASE  = 16'hD000,
  parameter logic [ADDR_W-1:0] FOLD_END = 16'hE000,
  parameter logic [PHYS_W-1:0] FOLD_OFS = 17'h03000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              flag_ram_rd,
  input  logic              flag_wr_en,
  input  logic              flag_bank2,
  input  logic              flag_alt_zp,
  output logic [1:0]        mem_sel,
  output logic [PHYS_W-1:0] mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] main_rdata,
  input  logic [DATA_W-1:0] aux_rdata,
  input  logic [DATA_W-1:0] rom_rdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  localparam int N_SRC = 3;

  bank_flags_t flags;
  region_e     region;
  logic        fold_win;
  logic        rd_accept;
  logic        wr_accept;
  sel_e        sel;
  logic        wr_blocked;
  logic        rom_path;

  assign flags     = '{ram_rd: flag_ram_rd, wr_en: flag_wr_en,
                       bank2: flag_bank2, alt_zp: flag_alt_zp};
  assign wr_accept = cpu_wr;
  assign rd_accept = cpu_rd & ~cpu_wr;

  bank_region_decode #(
    .ADDR_W(ADDR_W), .LOW_END(LOW_END), .SW_BASE(SW_BASE), .FOLD_END(FOLD_END)
  ) u_decode (
    .addr(cpu_addr), .region(region), .fold_win(fold_win)
  );

  bank_addr_xlate #(
    .ADDR_W(ADDR_W), .PHYS_W(PHYS_W), .SW_BASE(SW_BASE), .FOLD_OFS(FOLD_OFS)
  ) u_xlate (
    .addr(cpu_addr), .region(region), .fold_win(fold_win), .flags(flags),
    .do_rd(rd_accept), .do_wr(wr_accept), .sel(sel), .phys(mem_addr),
    .wr_blocked(wr_blocked), .rom_path(rom_path)
  );

  assign mem_sel   = sel;
  assign mem_re    = rd_accept && (sel != SEL_NONE);
  assign mem_we    = wr_accept && (sel != SEL_NONE) && !rom_path;
  assign mem_wdata = cpu_wdata;

  bank_rdata_mux #(.DATA_W(DATA_W), .N_SRC(N_SRC)) u_rmux (
    .clk(clk), .rst_n(rst_n), .sel(sel), .re(mem_re),
    .src_flat({rom_rdata, aux_rdata, main_rdata}),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk #(
  parameter int ADDR_W = 16,
  parameter int PHYS_W = 17,
  parameter logic [ADDR_W-1:0] LOW_END = 16'h0200,
  parameter logic [ADDR_W-1:0] SW_BASE = 16'hD000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic              flag_ram_rd,
  input logic              flag_wr_en,
  input logic              flag_alt_zp,
  input logic [1:0]        mem_sel,
  input logic [PHYS_W-1:0] mem_addr,
  input logic              mem_re,
  input logic              mem_we,
  input logic              rd_valid,
  input logic              wr_blocked
);

  logic [ADDR_W-1:0] rom_ofs;
  assign rom_ofs = cpu_addr - SW_BASE;

  // R1
  low_window_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cpu_rd || cpu_wr) && cpu_addr < LOW_END) |->
      (mem_sel == (flag_alt_zp ? 2'd2 : 2'd1)) && (mem_addr == PHYS_W'(cpu_addr)));

  // R2
  rom_read_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !cpu_wr && cpu_addr >= SW_BASE && !flag_ram_rd) |->
      (mem_sel == 2'd3) && (mem_addr == PHYS_W'(rom_ofs)) && mem_re);

  // R6
  write_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr >= SW_BASE && !flag_wr_en) |->
      (!mem_we && mem_sel == 2'd0 && wr_blocked));

  // R7
  no_rom_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_sel != 2'd3));

  // R8
  middle_passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cpu_rd || cpu_wr) && cpu_addr >= LOW_END && cpu_addr < SW_BASE) |->
      (mem_sel == 2'd1) && (mem_addr == PHYS_W'(cpu_addr)));

  // R9
  rd_valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> rd_valid);

  // R9
  rd_valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_re |=> !rd_valid);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_rd && !cpu_wr) |-> (mem_sel == 2'd0 && !mem_re && !mem_we));

  // R11
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_wr) |-> !mem_re);

endmodule

bind bank_mapper bank_mapper_chk #(
  .ADDR_W(ADDR_W), .PHYS_W(PHYS_W), .LOW_END(LOW_END), .SW_BASE(SW_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
  .flag_ram_rd(flag_ram_rd), .flag_wr_en(flag_wr_en), .flag_alt_zp(flag_alt_zp),
  .mem_sel(mem_sel), .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
  .rd_valid(rd_valid), .wr_blocked(wr_blocked)
);

// File: tb/test_bank_mapper.sv
`timescale 1ns/1ps
module test_bank_mapper;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic        flag_ram_rd = 1'b0, flag_wr_en = 1'b0, flag_bank2 = 1'b0, flag_alt_zp = 1'b0;
  logic [1:0]  mem_sel;
  logic [16:0] mem_addr;
  logic        mem_re, mem_we;
  logic [7:0]  mem_wdata;
  logic [7:0]  main_rdata = '0, aux_rdata = '0, rom_rdata = '0;
  logic [7:0]  rd_data;
  logic        rd_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bank_mapper i_bank_mapper (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .flag_ram_rd(flag_ram_rd), .flag_wr_en(flag_wr_en),
    .flag_bank2(flag_bank2), .flag_alt_zp(flag_alt_zp), .mem_sel(mem_sel),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .main_rdata(main_rdata), .aux_rdata(aux_rdata), .rom_rdata(rom_rdata),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // Store models behind the mapper, driven only by its outputs.
  logic [7:0] st_main [int];
  logic [7:0] st_aux  [int];
  // Ledger of what the requirements say each store should hold.
  logic [7:0] lg_main [int];
  logic [7:0] lg_aux  [int];

  function automatic logic [7:0] rom_pat(input int a);
    return 8'(a) ^ 8'(a >> 8) ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (mem_we) begin
      if (mem_sel == 2'd1) st_main[int'(mem_addr)] = mem_wdata;
      if (mem_sel == 2'd2) st_aux[int'(mem_addr)]  = mem_wdata;
    end
    if (mem_re) begin
      if (mem_sel == 2'd1) main_rdata <= st_main.exists(int'(mem_addr)) ? st_main[int'(mem_addr)] : 8'h00;
      if (mem_sel == 2'd2) aux_rdata  <= st_aux.exists(int'(mem_addr))  ? st_aux[int'(mem_addr)]  : 8'h00;
      if (mem_sel == 2'd3) rom_rdata  <= rom_pat(int'(mem_addr));
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Expected mapping, from the requirements. fl = {ram_rd, wr_en, bank2, alt_zp}
  task automatic expect_map(input logic [15:0] a, input logic rd, input logic wr,
                            input logic [3:0] fl, output int esel, output int eaddr,
                            output bit ere, output bit ewe);
    int ram;
    ram = fl[0] ? 2 : 1;
    esel = 0; eaddr = int'(a); ere = 0; ewe = 0;
    if (!rd && !wr) return;
    if (a <= 16'h01FF) esel = ram;
    else if (a < 16'hD000) esel = 1;
    else begin
      if (fl[1] && a[15:12] == 4'hD) eaddr = int'(a) + 'h3000;
      if (wr) begin
        if (fl[2]) esel = ram;
        else eaddr = int'(a);
      end else if (fl[3]) esel = ram;
      else begin
        esel = 3;
        eaddr = int'(a) - 'hD000;
      end
    end
    ewe = wr && esel != 0;
    ere = !wr && esel != 0;
  endtask

  task automatic op(input string req, input logic [15:0] a, input logic rd, input logic wr,
                    input logic [7:0] wd, input logic [3:0] fl);
    int esel, eaddr, edat;
    bit ere, ewe;
    expect_map(a, rd, wr, fl, esel, eaddr, ere, ewe);
    @(negedge clk);
    cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_wdata = wd;
    {flag_ram_rd, flag_wr_en, flag_bank2, flag_alt_zp} = fl;
    #1;
    check(req, "mem_sel", int'(mem_sel), esel);
    if (esel != 0) check(req, "mem_addr", int'(mem_addr), eaddr);
    check(req, "mem_re", int'(mem_re), int'(ere));
    check(req, "mem_we", int'(mem_we), int'(ewe));
    edat = 0;
    if (ewe && esel == 1) lg_main[eaddr] = wd;
    if (ewe && esel == 2) lg_aux[eaddr] = wd;
    if (esel == 1 && lg_main.exists(eaddr)) edat = int'(lg_main[eaddr]);
    if (esel == 2 && lg_aux.exists(eaddr))  edat = int'(lg_aux[eaddr]);
    if (esel == 3) edat = int'(rom_pat(eaddr));
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
    #1;
    check(req, "rd_valid", int'(rd_valid), int'(ere));
    if (ere) check(req, "rd_data", int'(rd_data), edat);
  endtask

  task automatic t_reset;
    #1;
    check("R10", "reset mem_sel", int'(mem_sel), 0);
    check("R10", "reset mem_we", int'(mem_we), 0);
    check("R9", "reset rd_valid", int'(rd_valid), 0);
  endtask

  task automatic t_low_window;
    op("R1", 16'h0000, 0, 1, 8'd123, 4'b0000);
    op("R1", 16'h0000, 0, 1, 8'd234, 4'b0001);
    op("R1", 16'h0000, 1, 0, 8'd0, 4'b0000);
    op("R1", 16'h0000, 1, 0, 8'd0, 4'b0001);
    op("R1", 16'h01FF, 0, 1, 8'h3C, 4'b1111);
    op("R1", 16'h01FF, 1, 0, 8'd0, 4'b0001);
    op("R1", 16'h01FF, 1, 0, 8'd0, 4'b0000);
  endtask

  task automatic t_middle;
    op("R8", 16'h0200, 0, 1, 8'h41, 4'b0101);
    op("R8", 16'h0200, 1, 0, 8'd0, 4'b1011);
    op("R8", 16'hCFFF, 0, 1, 8'h42, 4'b0001);
    op("R8", 16'hCFFF, 1, 0, 8'd0, 4'b0000);
  endtask

  task automatic t_rom_read;
    op("R2", 16'hD000, 1, 0, 8'd0, 4'b0000);
    op("R2", 16'hFFFF, 1, 0, 8'd0, 4'b0011);
    op("R2", 16'hE123, 1, 0, 8'd0, 4'b0100);
  endtask

  task automatic t_bank2;
    op("R3", 16'hD000, 0, 1, 8'h11, 4'b1110);
    op("R4", 16'hD000, 0, 1, 8'h22, 4'b1100);
    op("R3", 16'hD000, 1, 0, 8'd0, 4'b1010);
    op("R4", 16'hD000, 1, 0, 8'd0, 4'b1000);
    op("R3", 16'hDFFF, 0, 1, 8'h33, 4'b0110);
    op("R3", 16'hDFFF, 1, 0, 8'd0, 4'b1010);
    op("R4", 16'hE000, 0, 1, 8'h44, 4'b1110);
    op("R4", 16'hE000, 1, 0, 8'd0, 4'b1000);
  endtask

  task automatic t_alt_upper;
    op("R5", 16'hD005, 0, 1, 8'h66, 4'b1111);
    op("R5", 16'hD005, 1, 0, 8'd0, 4'b1011);
    op("R5", 16'hD005, 1, 0, 8'd0, 4'b1010);
    op("R5", 16'hF00D, 0, 1, 8'h67, 4'b1101);
    op("R5", 16'hF00D, 1, 0, 8'd0, 4'b1001);
  endtask

  task automatic t_protect;
    op("R6", 16'hD010, 0, 1, 8'h55, 4'b1100);
    op("R6", 16'hD010, 0, 1, 8'h77, 4'b1000);
    op("R6", 16'hD010, 1, 0, 8'd0, 4'b1000);
    op("R6", 16'hFF00, 0, 1, 8'h78, 4'b0011);
    op("R6", 16'h1234, 0, 1, 8'h79, 4'b0000);
    op("R6", 16'h1234, 1, 0, 8'd0, 4'b0000);
  endtask

  task automatic t_under_rom;
    op("R7", 16'hE100, 0, 1, 8'h99, 4'b0100);
    op("R7", 16'hE100, 1, 0, 8'd0, 4'b0100);
    op("R7", 16'hE100, 1, 0, 8'd0, 4'b1100);
    op("R7", 16'hD100, 0, 1, 8'h9A, 4'b0110);
    op("R7", 16'hD100, 1, 0, 8'd0, 4'b1010);
  endtask

  task automatic t_idle;
    op("R10", 16'hD000, 0, 0, 8'd0, 4'b0000);
    op("R10", 16'h0010, 0, 0, 8'd0, 4'b1111);
  endtask

  task automatic t_both;
    op("R11", 16'hD200, 1, 1, 8'hA5, 4'b0100);
    op("R11", 16'hD200, 1, 0, 8'd0, 4'b1100);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_low_window;
    t_middle;
    t_rom_read;
    t_bank2;
    t_alt_upper;
    t_protect;
    t_under_rom;
    t_idle;
    t_both;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule